// File: doc/BRIEF.md
# Masked Eight-Lane SIMD Execute Stage

This block is the execute stage of a narrow SIMD core. On every clock one decoded command reaches all eight lanes at once. Each lane owns a small private integer register file and an ALU, and all lanes apply the same operation to their own data. A per-lane active mask decides which lanes commit. Lanes outside the mask still see the instruction, but their register files do not change.

Divergent control flow is handled with per-lane conditions and a mask stack. A compare command records one condition bit per lane. An if command saves the current mask and narrows it to the lanes whose condition is true. An else command switches to the saved lanes that were left out. An end-if command restores the saved mask. Both sides of a branch therefore run one after the other. An external sequencer sees the active mask. When the mask is empty it can skip that path, and a command issued under an empty mask has no effect. Two counters report how many instructions did useful work and how many lane results were committed, so the ratio gives lane utilization.

Top module: `simd_pred_exec`

## Requirements
- R1: After reset the active mask is all ones, the stack depth is 0, the error flag is 0 and both counters are 0. Register 0 of lane L holds L and every other register holds 0.
- R2: The cmd encodings are 0 nop, 1 execute, 2 compare, 3 if, 4 else, 5 end-if. For execute, the op encodings are 0 add rs1+rs2, 1 subtract rs1-rs2, 2 multiply (low 32 bits of rs1*rs2) and 3 move-immediate. Every active lane writes its own result to rd, and the value is readable one cycle later.
- R3: A lane whose mask bit is 0 keeps all of its registers unchanged during execute.
- R4: Compare sets lane L's condition bit to (signed reg[rs1] > signed imm). It changes neither the mask nor any register.
- R5: If (depth below 4) pushes the current mask, sets the mask to mask AND condition, and raises the depth by one.
- R6: Else (depth above 0) sets the mask to saved-top AND NOT current mask. The depth does not change.
- R7: End-if (depth above 0) restores the saved top mask and lowers the depth by one.
- R8: The stack holds up to 4 nested levels. If at depth 4, or else/end-if at depth 0, sets a sticky error flag and leaves the mask and depth unchanged. Only reset clears the flag.
- R9: Execute under an empty mask changes no register and no counter.
- R10: Each execute with a non-empty mask adds 1 to the issue counter and adds the number of active lanes to the lane-operation counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code |
| op | input | 2 | Lane operation for execute |
| rd | input | 2 | Destination register index |
| rs1 | input | 2 | First source register index |
| rs2 | input | 2 | Second source register index |
| imm | input | 32 | Immediate for move and compare |
| rd_idx | input | 2 | Register index read from every lane |
| rd_data | output | 256 | Lane L's register rd_idx at bits [32L+31:32L] |
| act_mask | output | 8 | Current active lane mask |
| mask_depth | output | 3 | Mask stack depth |
| stack_err | output | 1 | Sticky stack misuse flag |
| lane_ops | output | 32 | Committed lane-operation count |
| issue_cnt | output | 32 | Useful execute count |

## Verification
Some properties are checked on every cycle. An idle lane's register file must stay put. An if may only narrow the mask, an else must yield lanes disjoint from the path before it, and an end-if may only widen the mask. The stack depth must stay in bounds, the error flag must stay set once raised, and the counters must step as issue requires. Other behaviour can only be shown by the bench's scenarios. These are the actual arithmetic per lane, the nested branch sequence with its exact masks, a path whose mask is empty, and the overflow and underflow cases. The bench checks them against its own model of lanes, conditions and stack.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_EXEC  = 3'd1,
    CMD_CMP   = 3'd2,
    CMD_IF    = 3'd3,
    CMD_ELSE  = 3'd4,
    CMD_ENDIF = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_MUL  = 2'd2,
    OP_MOVI = 2'd3
  } op_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_lane_pkg::*;
#(
  parameter int W       = 32,
  parameter int REGS    = 4,
  parameter int LANE_ID = 0,
  localparam int RW     = $clog2(REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          cmp_en,
  input  op_e           op,
  input  logic [RW-1:0] rd,
  input  logic [RW-1:0] rs1,
  input  logic [RW-1:0] rs2,
  input  logic [W-1:0]  imm,
  input  logic [RW-1:0] rd_idx,
  output logic [W-1:0]  rd_val,
  output logic          cond_q
);
  logic [REGS-1:0][W-1:0] rf;
  logic [W-1:0] result;

  function automatic logic [W-1:0] lane_alu(input op_e o, input logic [W-1:0] a,
                                            input logic [W-1:0] b, input logic [W-1:0] k);
    logic [W-1:0] r;
    case (o)
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_MUL:  r = a * b;
      default: r = k;
    endcase
    return r;
  endfunction

  assign result = lane_alu(op, rf[rs1], rf[rs2], imm);
  assign rd_val = rf[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) rf[i] <= (i == 0) ? W'(LANE_ID) : '0;
      cond_q <= 1'b0;
    end else begin
      if (wr_en) rf[rd] <= result;
      if (cmp_en) cond_q <= $signed(rf[rs1]) > $signed(imm);
    end
  end

  assert_idle_lane_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rf));
endmodule

// File: rtl/simd_mask_ctrl.sv
module simd_mask_ctrl #(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_if,
  input  logic             do_else,
  input  logic             do_endif,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] active,
  output logic [DW-1:0]    depth,
  output logic             err
);
  logic [LANES-1:0] stack_mem [DEPTH];
  logic [LANES-1:0] top;
  logic full, empty, push_ok, else_ok, pop_ok, misuse;

  assign full    = (depth == DW'(DEPTH));
  assign empty   = (depth == '0);
  assign top     = empty ? '1 : stack_mem[depth - 1'b1];
  assign push_ok = do_if && !full;
  assign else_ok = do_else && !empty;
  assign pop_ok  = do_endif && !empty;
  assign misuse  = (do_if && full) || ((do_else || do_endif) && empty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '1;
      depth  <= '0;
      err    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) stack_mem[i] <= '0;
    end else begin
      if (misuse) err <= 1'b1;
      if (push_ok) begin
        stack_mem[depth] <= active;
        depth  <= depth + 1'b1;
        active <= active & cond;
      end else if (else_ok) begin
        active <= top & ~active;
      end else if (pop_ok) begin
        active <= top;
        depth  <= depth - 1'b1;
      end
    end
  end

  assert_if_narrows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> (active & ~$past(active)) == '0);
  assert_else_disjoint_R6: assert property (@(posedge clk) disable iff (!rst_n)
    else_ok |=> (active & $past(active)) == '0);
  assert_endif_widens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> ($past(active) & ~active) == '0);
  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_misuse_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    misuse |=> $stable(depth) && $stable(active));
endmodule

// File: rtl/simd_util_counter.sv
module simd_util_counter #(
  parameter int LANES = 8,
  parameter int CW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [LANES-1:0] mask,
  output logic [CW-1:0]    lane_ops,
  output logic [CW-1:0]    issue_cnt
);
  function automatic logic [CW-1:0] ones(input logic [LANES-1:0] m);
    logic [CW-1:0] s = '0;
    for (int i = 0; i < LANES; i++) s = s + CW'(m[i]);
    return s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_ops  <= '0;
      issue_cnt <= '0;
    end else if (issue) begin
      lane_ops  <= lane_ops + ones(mask);
      issue_cnt <= issue_cnt + 1'b1;
    end
  end

  assert_issue_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> issue_cnt == $past(issue_cnt) + 1'b1);
  assert_ops_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (lane_ops - $past(lane_ops)) <= CW'(LANES) && lane_ops != $past(lane_ops));
endmodule

// File: rtl/simd_pred_exec.sv
module simd_pred_exec
  import simd_lane_pkg::*;
#(
  parameter int LANES       = 8,
  parameter int DATA_W      = 32,
  parameter int REGS        = 4,
  parameter int STACK_DEPTH = 4,
  parameter int CNT_W       = 32,
  localparam int RW         = $clog2(REGS),
  localparam int DW         = $clog2(STACK_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              cmd,
  input  logic [1:0]              op,
  input  logic [RW-1:0]           rd,
  input  logic [RW-1:0]           rs1,
  input  logic [RW-1:0]           rs2,
  input  logic [DATA_W-1:0]       imm,
  input  logic [RW-1:0]           rd_idx,
  output logic [LANES*DATA_W-1:0] rd_data,
  output logic [LANES-1:0]        act_mask,
  output logic [DW-1:0]           mask_depth,
  output logic                    stack_err,
  output logic [CNT_W-1:0]        lane_ops,
  output logic [CNT_W-1:0]        issue_cnt
);
  cmd_e c;
  op_e  o;
  logic is_exec, is_cmp, useful_issue;
  logic [LANES-1:0] lane_we, lane_cond;

  assign c            = cmd_e'(cmd);
  assign o            = op_e'(op);
  assign is_exec      = (c == CMD_EXEC);
  assign is_cmp       = (c == CMD_CMP);
  assign lane_we      = is_exec ? act_mask : '0;
  assign useful_issue = is_exec && (act_mask != '0);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    simd_lane #(.W(DATA_W), .REGS(REGS), .LANE_ID(l)) u_lane (
      .clk(clk), .rst_n(rst_n), .wr_en(lane_we[l]), .cmp_en(is_cmp),
      .op(o), .rd(rd), .rs1(rs1), .rs2(rs2), .imm(imm), .rd_idx(rd_idx),
      .rd_val(rd_data[l*DATA_W +: DATA_W]), .cond_q(lane_cond[l])
    );
  end

  simd_mask_ctrl #(.LANES(LANES), .DEPTH(STACK_DEPTH)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .do_if(c == CMD_IF), .do_else(c == CMD_ELSE), .do_endif(c == CMD_ENDIF),
    .cond(lane_cond), .active(act_mask), .depth(mask_depth), .err(stack_err)
  );

  simd_util_counter #(.LANES(LANES), .CW(CNT_W)) u_util (
    .clk(clk), .rst_n(rst_n), .issue(useful_issue), .mask(act_mask),
    .lane_ops(lane_ops), .issue_cnt(issue_cnt)
  );

  assert_empty_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_exec && act_mask == '0) |=> $stable(issue_cnt) && $stable(lane_ops));
  assert_cmp_keeps_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp |=> $stable(act_mask) && $stable(mask_depth));
endmodule

// File: tb/simd_pred_exec_bench.sv
`timescale 1ns/100ps
module simd_pred_exec_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd = '0;
  logic [1:0] op = '0, rd = '0, rs1 = '0, rs2 = '0, rd_idx = '0;
  logic [31:0] imm = '0;
  logic [255:0] rd_data;
  logic [7:0] act_mask;
  logic [2:0] mask_depth;
  logic stack_err;
  logic [31:0] lane_ops, issue_cnt;

  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  simd_pred_exec u_simd_pred_exec (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .op(op), .rd(rd), .rs1(rs1), .rs2(rs2),
    .imm(imm), .rd_idx(rd_idx), .rd_data(rd_data), .act_mask(act_mask),
    .mask_depth(mask_depth), .stack_err(stack_err), .lane_ops(lane_ops),
    .issue_cnt(issue_cnt)
  );

  // reference state
  logic [31:0] m_rf [8][4];
  logic [7:0]  m_mask, m_cond;
  logic [7:0]  m_stk [4];
  int          m_depth;
  logic        m_err;
  logic [31:0] m_ops, m_iss;

  // {cmd, op, rd, rs1, rs2, imm}
  localparam logic [42:0] VEC [16] = '{
    {3'd1, 2'd3, 2'd2, 2'd0, 2'd0, 32'd3},
    {3'd1, 2'd1, 2'd1, 2'd0, 2'd2, 32'd0},
    {3'd2, 2'd0, 2'd0, 2'd1, 2'd0, 32'd0},
    {3'd3, 2'd0, 2'd0, 2'd0, 2'd0, 32'd0},
    {3'd1, 2'd2, 2'd3, 2'd1, 2'd1, 32'd0},
    {3'd2, 2'd0, 2'd0, 2'd0, 2'd0, 32'd5},
    {3'd3, 2'd0, 2'd0, 2'd0, 2'd0, 32'd0},
    {3'd1, 2'd0, 2'd3, 2'd3, 2'd0, 32'd0},
    {3'd4, 2'd0, 2'd0, 2'd0, 2'd0, 32'd0},
    {3'd1, 2'd3, 2'd3, 2'd0, 2'd0, 32'd100},
    {3'd5, 2'd0, 2'd0, 2'd0, 2'd0, 32'd0},
    {3'd4, 2'd0, 2'd0, 2'd0, 2'd0, 32'd0},
    {3'd1, 2'd1, 2'd3, 2'd2, 2'd0, 32'd0},
    {3'd5, 2'd0, 2'd0, 2'd0, 2'd0, 32'd0},
    {3'd1, 2'd0, 2'd2, 2'd2, 2'd2, 32'd0},
    {3'd1, 2'd2, 2'd1, 2'd1, 2'd2, 32'd0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int l = 0; l < 8; l++)
      for (int r = 0; r < 4; r++) m_rf[l][r] = (r == 0) ? 32'(l) : 32'd0;
    m_mask = 8'hFF; m_cond = '0; m_depth = 0; m_err = 0; m_ops = 0; m_iss = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic check_state(input string req);
    chk(act_mask == m_mask, req, "mask", 32'(act_mask), 32'(m_mask));
    chk(32'(mask_depth) == 32'(m_depth), req, "depth", 32'(mask_depth), 32'(m_depth));
    chk(stack_err == m_err, req, "err", 32'(stack_err), 32'(m_err));
    for (int r = 0; r < 4; r++) begin
      rd_idx = 2'(r);
      #0.2;
      for (int l = 0; l < 8; l++)
        chk(rd_data[l*32 +: 32] == m_rf[l][r], req, $sformatf("lane%0d r%0d", l, r),
            rd_data[l*32 +: 32], m_rf[l][r]);
    end
  endtask

  task automatic step(input logic [42:0] v);
    logic [2:0] c; logic [1:0] o, d, a, b; logic [31:0] k; string tag;
    {c, o, d, a, b, k} = v;
    @(negedge clk);
    cmd = c; op = o; rd = d; rs1 = a; rs2 = b; imm = k;
    @(posedge clk);
    #1;
    cmd = '0;
    tag = "R2";
    case (c)
      3'd1: begin
        if (m_mask == 0) tag = "R9"; else tag = "R3";
        if (m_mask != 0) begin
          m_iss++;
          for (int l = 0; l < 8; l++) m_ops += 32'(m_mask[l]);
        end
        for (int l = 0; l < 8; l++) if (m_mask[l]) begin
          logic [31:0] x, y;
          x = m_rf[l][a]; y = m_rf[l][b];
          case (o)
            2'd0: m_rf[l][d] = x + y;
            2'd1: m_rf[l][d] = x - y;
            2'd2: m_rf[l][d] = x * y;
            default: m_rf[l][d] = k;
          endcase
        end
      end
      3'd2: begin
        tag = "R4";
        for (int l = 0; l < 8; l++) m_cond[l] = $signed(m_rf[l][a]) > $signed(k);
      end
      3'd3: begin
        tag = "R5";
        if (m_depth == 4) begin m_err = 1; tag = "R8"; end
        else begin m_stk[m_depth] = m_mask; m_depth++; m_mask = m_mask & m_cond; end
      end
      3'd4: begin
        tag = "R6";
        if (m_depth == 0) begin m_err = 1; tag = "R8"; end
        else m_mask = m_stk[m_depth-1] & ~m_mask;
      end
      3'd5: begin
        tag = "R7";
        if (m_depth == 0) begin m_err = 1; tag = "R8"; end
        else begin m_mask = m_stk[m_depth-1]; m_depth--; end
      end
      default: ;
    endcase
    check_state(tag);
  endtask

  task automatic check_counters(input string req);
    chk(issue_cnt == m_iss, req, "issue_cnt", issue_cnt, m_iss);
    chk(lane_ops == m_ops, req, "lane_ops", lane_ops, m_ops);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    check_state("R1");
    check_counters("R1");

    // nested divergent program, R2 through R7
    for (int i = 0; i < 16; i++) step(VEC[i]);
    check_counters("R10");

    // empty path: R9
    step({3'd2, 2'd0, 2'd0, 2'd0, 2'd0, 32'd100});
    step({3'd3, 2'd0, 2'd0, 2'd0, 2'd0, 32'd0});
    chk(act_mask == 8'h00, "R9", "empty mask", 32'(act_mask), 32'd0);
    step({3'd1, 2'd3, 2'd1, 2'd0, 2'd0, 32'd55});
    check_counters("R9");
    step({3'd5, 2'd0, 2'd0, 2'd0, 2'd0, 32'd0});

    // overflow: R8
    do_reset();
    step({3'd2, 2'd0, 2'd0, 2'd0, 2'd0, 32'hFFFF_FFFF});
    for (int i = 0; i < 5; i++) step({3'd3, 2'd0, 2'd0, 2'd0, 2'd0, 32'd0});
    chk(stack_err == 1'b1, "R8", "overflow err", 32'(stack_err), 32'd1);
    for (int i = 0; i < 4; i++) step({3'd5, 2'd0, 2'd0, 2'd0, 2'd0, 32'd0});
    chk(stack_err == 1'b1, "R8", "err sticky", 32'(stack_err), 32'd1);

    // underflow by end-if and by else: R8
    do_reset();
    step({3'd5, 2'd0, 2'd0, 2'd0, 2'd0, 32'd0});
    do_reset();
    step({3'd4, 2'd0, 2'd0, 2'd0, 2'd0, 32'd0});
    chk(act_mask == 8'hFF, "R8", "mask after bad else", 32'(act_mask), 32'hFF);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule